// File: doc/BRIEF.md
# Multiply-Accumulate and Leading-Bit Count Unit

This unit is the integer multiply side of a small 32-bit processor core. It keeps a 64-bit accumulator split into a high word and a low word. Operations come in through one valid/ready port as an opcode with two operands. A plain multiply replaces the accumulator with the product. Multiply-add and multiply-subtract each change the accumulator in a single step that nothing can split. Signed and unsigned forms are chosen by the opcode.

A multiply-class operation takes two clocks. The unit reports busy during the second clock and refuses new work while busy, which gives a rate of one operation every two clocks. A second path counts leading zeros, or leading ones, of the first operand in one cycle and presents the count on a result port with a one-cycle valid pulse.

Software-visible state is reached through direct write strobes for each accumulator word, and both words are always readable. When a direct write lands on the same edge that a multiply completes, the multiply result wins.

Top module: `mac_clz_unit`

## Requirements
- R1: An accepted multiply-class operation (codes 0 to 5) raises busy for exactly the one following cycle. op_ready is low during that cycle, so the next operation is accepted no sooner than two clocks after the previous one.
- R2: Code 0 (signed) and code 1 (unsigned) replace the accumulator with the 64-bit product. The upper half goes to hi and the lower half to lo, and both are visible after the second rising edge following acceptance.
- R3: Code 2 (signed) and code 3 (unsigned) add the product to {hi,lo}, wrapping modulo 2^64.
- R4: Code 4 (signed) and code 5 (unsigned) subtract the product from {hi,lo}, wrapping modulo 2^64.
- R5: Code 6 puts, in the cycle after acceptance, the number of zero bits above the highest one bit of op_a on cnt_result, with cnt_valid high for that single cycle. cnt_valid is low at all other times.
- R6: Code 7 returns, with the same timing, the number of one bits above the highest zero bit of op_a.
- R7: A zero count of an all-zero word, or a one count of an all-one word, returns 32.
- R8: When no multiply completes, hi_we or lo_we loads hi_wdata or lo_wdata into the matching word at the next edge.
- R9: A direct write on the edge where a multiply completes is discarded, and the accumulator takes the multiply result.
- R10: After reset, hi and lo are zero, busy and cnt_valid are low, and op_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can take an operation |
| op_code | input | 3 | Operation code (0..7) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| busy | output | 1 | Multiply in its second cycle |
| cnt_valid | output | 1 | Count result valid pulse |
| cnt_result | output | 6 | Leading zero/one count |
| hi_we | input | 1 | Direct write strobe, high word |
| hi_wdata | input | 32 | Direct write data, high word |
| lo_we | input | 1 | Direct write strobe, low word |
| lo_wdata | input | 32 | Direct write data, low word |
| hi | output | 32 | Accumulator high word |
| lo | output | 32 | Accumulator low word |

## Verification
A count result is due one rising edge after its acceptance edge. An accumulator result is due two edges after, and busy is due for the single cycle in between. The bench registers every accepted operation at the rising edge into a one-stage and a two-stage delay line. At the next falling edge it compares the matching delay stage against the front of the expected-value queue, so each comparison lands in the cycle the result becomes due. Direct writes are checked at the falling edge one edge after the strobe, and the priority case places its strobe exactly in the busy cycle.

// File: rtl/mac_clz_unit.sv
module mac_clz_unit #(
  parameter int W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_valid,
  output logic                       op_ready,
  input  logic [2:0]                 op_code,
  input  logic [W-1:0]               op_a,
  input  logic [W-1:0]               op_b,
  output logic                       busy,
  output logic                       cnt_valid,
  output logic [$clog2(W+1)-1:0]     cnt_result,
  input  logic                       hi_we,
  input  logic [W-1:0]               hi_wdata,
  input  logic                       lo_we,
  input  logic [W-1:0]               lo_wdata,
  output logic [W-1:0]               hi,
  output logic [W-1:0]               lo
);
  localparam int AW = 2 * W;
  localparam int CW = $clog2(W + 1);

  logic          busy_q, cnt_v_q;
  logic [2:0]    kind_q;
  logic [W-1:0]  a_q, b_q, hi_q, lo_q, scan;
  logic [CW-1:0] cnt_q, lead;
  logic [AW-1:0] ext_a, ext_b, prod, acc, acc_nxt;
  logic          fire, is_cnt, sgn;

  assign op_ready   = !busy_q;
  assign busy       = busy_q;
  assign cnt_valid  = cnt_v_q;
  assign cnt_result = cnt_q;
  assign hi         = hi_q;
  assign lo         = lo_q;

  assign fire   = op_valid && op_ready;
  assign is_cnt = (op_code[2:1] == 2'b11);
  assign sgn    = !kind_q[0];

  assign ext_a = {{W{sgn & a_q[W-1]}}, a_q};
  assign ext_b = {{W{sgn & b_q[W-1]}}, b_q};
  assign prod  = ext_a * ext_b;
  assign acc   = {hi_q, lo_q};

  always_comb begin
    case (kind_q[2:1])
      2'b01:   acc_nxt = acc + prod;
      2'b10:   acc_nxt = acc - prod;
      default: acc_nxt = prod;
    endcase
  end

  assign scan = op_code[0] ? ~op_a : op_a;

  always_comb begin
    lead = CW'(W);
    for (int i = 0; i < W; i++)
      if (scan[i]) lead = CW'(W - 1 - i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_v_q <= 1'b0;
      cnt_q   <= '0;
      kind_q  <= '0;
      a_q     <= '0;
      b_q     <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      busy_q  <= fire && !is_cnt;
      cnt_v_q <= fire && is_cnt;
      if (fire && is_cnt) cnt_q <= lead;
      if (fire && !is_cnt) begin
        kind_q <= op_code;
        a_q    <= op_a;
        b_q    <= op_b;
      end
      if (busy_q) begin
        hi_q <= acc_nxt[AW-1:W];
        lo_q <= acc_nxt[W-1:0];
      end else begin
        if (hi_we) hi_q <= hi_wdata;
        if (lo_we) lo_q <= lo_wdata;
      end
    end
  end
endmodule

// File: rtl/mac_clz_unit_chk.sv
module mac_clz_unit_chk #(
  parameter int W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   op_valid,
  input logic                   op_ready,
  input logic [2:0]             op_code,
  input logic [W-1:0]           op_a,
  input logic [W-1:0]           op_b,
  input logic                   busy,
  input logic                   cnt_valid,
  input logic [$clog2(W+1)-1:0] cnt_result,
  input logic                   hi_we,
  input logic [W-1:0]           hi_wdata,
  input logic [W-1:0]           hi,
  input logic [W-1:0]           lo
);
  logic fire;
  assign fire = op_valid && op_ready;

  a_r1_busy_after_mul: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_code[2:1] != 2'b11) |=> busy);

  a_r1_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r2_unsigned_product: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_code == 3'd1) |=> ##1
      ({hi, lo} == ({{W{1'b0}}, $past(op_a, 2)} * {{W{1'b0}}, $past(op_b, 2)})));

  a_r5_count_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_code[2:1] == 2'b11) |=> cnt_valid);

  a_r5_count_only_after: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |-> $past(fire && op_code[2:1] == 2'b11));

  a_r7_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_code == 3'd6 && op_a == '0) |=> (cnt_result == W));

  a_r8_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hi_we) |=> (hi == $past(hi_wdata)));
endmodule

bind mac_clz_unit mac_clz_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .op_a(op_a), .op_b(op_b), .busy(busy),
  .cnt_valid(cnt_valid), .cnt_result(cnt_result), .hi_we(hi_we),
  .hi_wdata(hi_wdata), .hi(hi), .lo(lo)
);

// File: tb/test_mac_clz_unit.sv
`timescale 1ns/1ps
module test_mac_clz_unit;
  logic        clk = 0, rst_n = 0;
  logic        op_valid = 0, hi_we = 0, lo_we = 0;
  logic [2:0]  op_code = 0;
  logic [31:0] op_a = 0, op_b = 0, hi_wdata = 0, lo_wdata = 0;
  logic        op_ready, busy, cnt_valid;
  logic [5:0]  cnt_result;
  logic [31:0] hi, lo;

  int checks = 0, fails = 0;
  logic [63:0] model = 0;
  logic [63:0] acc_q[$];
  string       acc_tag[$];
  logic [5:0]  cnt_q[$];
  string       cnt_tag[$];
  logic        mul_d1 = 0, mul_d2 = 0, cnt_d1 = 0;
  realtime     t_acc = 0, t_prev = 0;

  always #2.5 clk = ~clk;

  mac_clz_unit i_mac_clz_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .busy(busy),
    .cnt_valid(cnt_valid), .cnt_result(cnt_result), .hi_we(hi_we),
    .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata), .hi(hi), .lo(lo)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] product(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (c[0]) return {32'b0, a} * {32'b0, b};
    return 64'(sa * sb);
  endfunction

  function automatic logic [5:0] leading(input logic [31:0] v, input logic ones);
    int n = 0;
    while (n < 32 && v[31 - n] == ones) n++;
    return 6'(n);
  endfunction

  task automatic do_op(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b, input string tag);
    if (c[2:1] == 2'b11) begin
      cnt_q.push_back(leading(a, c[0]));
      cnt_tag.push_back(tag);
    end else begin
      case (c[2:1])
        2'b00: model = product(c, a, b);
        2'b01: model = model + product(c, a, b);
        default: model = model - product(c, a, b);
      endcase
      acc_q.push_back(model);
      acc_tag.push_back(tag);
    end
    op_valid = 1; op_code = c; op_a = a; op_b = b;
    while (!op_ready) @(negedge clk);
    @(posedge clk);
    if (c[2:1] != 2'b11) begin t_prev = t_acc; t_acc = $realtime; end
    @(negedge clk);
    op_valid = 0;
  endtask

  always @(posedge clk) begin
    mul_d2 <= mul_d1;
    mul_d1 <= op_valid && op_ready && op_code[2:1] != 2'b11;
    cnt_d1 <= op_valid && op_ready && op_code[2:1] == 2'b11;
  end

  always @(negedge clk) if (rst_n) begin
    if (mul_d1) begin
      check("R1 busy in second cycle", {63'b0, busy}, 64'd1);
      check("R1 ready low while busy", {63'b0, op_ready}, 64'd0);
    end
    if (cnt_d1) begin
      check("R5 cnt_valid pulse", {63'b0, cnt_valid}, 64'd1);
      if (cnt_q.size() > 0) check(cnt_tag.pop_front(), {58'b0, cnt_result}, {58'b0, cnt_q.pop_front()});
    end else begin
      check("R5 cnt_valid idle low", {63'b0, cnt_valid}, 64'd0);
    end
    if (mul_d2 && acc_q.size() > 0) check(acc_tag.pop_front(), {hi, lo}, acc_q.pop_front());
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 hi reset", {32'b0, hi}, 0);
    check("R10 lo reset", {32'b0, lo}, 0);
    check("R10 busy reset", {63'b0, busy}, 0);
    check("R10 ready reset", {63'b0, op_ready}, 1);
    rst_n = 1;
    @(negedge clk);

    do_op(3'd0, 32'hFFFF_FFFD, 32'd7, "R2 signed multiply");
    do_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 unsigned multiply");
    check("R1 two-clock issue spacing", 64'(int'(t_acc - t_prev)), 64'd10);
    do_op(3'd2, 32'd5, 32'hFFFF_FFFC, "R3 signed multiply-add");
    do_op(3'd3, 32'h8000_0000, 32'd4, "R3 unsigned multiply-add");
    do_op(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 signed multiply-subtract");
    do_op(3'd0, 32'd0, 32'd0, "R2 clear by multiply");
    do_op(3'd5, 32'd3, 32'd2, "R4 unsigned subtract wraps below zero");
    @(negedge clk);

    hi_we = 1; hi_wdata = 32'hFFFF_FFFF; lo_we = 1; lo_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    hi_we = 0; lo_we = 0;
    check("R8 direct hi write", {32'b0, hi}, 64'hFFFF_FFFF);
    check("R8 direct lo write", {32'b0, lo}, 64'hFFFF_FFFF);
    model = 64'hFFFF_FFFF_FFFF_FFFF;
    do_op(3'd3, 32'd1, 32'd1, "R3 add wraps at 2^64");
    @(negedge clk);

    do_op(3'd0, 32'h1234_5678, 32'h10, "R9 multiply beats coinciding write");
    hi_we = 1; hi_wdata = 32'hDEAD_BEEF; lo_we = 1; lo_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    hi_we = 0; lo_we = 0;
    check("R9 hi keeps multiply result", {32'b0, hi}, {32'b0, model[63:32]});
    check("R9 lo keeps multiply result", {32'b0, lo}, {32'b0, model[31:0]});

    do_op(3'd6, 32'h0001_0000, 0, "R5 count zeros");
    do_op(3'd6, 32'h8000_0000, 0, "R5 count zeros top bit set");
    do_op(3'd6, 32'h0, 0, "R7 zero count of zero word");
    do_op(3'd7, 32'hFFFF_0000, 0, "R6 count ones");
    do_op(3'd7, 32'h7FFF_FFFF, 0, "R6 count ones top bit clear");
    do_op(3'd7, 32'hFFFF_FFFF, 0, "R7 one count of all-one word");
    do_op(3'd6, 32'h0000_0001, 0, "R5 count zeros lowest bit");
    check("R5 count leaves accumulator", {hi, lo}, model);

    repeat (4) @(negedge clk);
    check("R5 queues drained", 64'(cnt_q.size() + acc_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule